// File: doc/BRIEF.md
# Three-Level Space-Vector PWM Sequencer

This block generates the switching pattern of a three-phase, three-level inverter over one fixed-length PWM period. Each phase leg can sit at the top rail (P), the midpoint (O) or the bottom rail (N). The block works the way three-level space-vector modulation is usually reduced to the two-level case. One of six small hexagons is chosen, each centred on a short vector. The centre vector stands in for the zero vector. Inside the hexagon, two adjacent active vectors are applied for their given dwell times. Software or an upstream controller supplies the hexagon index, the triangle inside it and the two dwell times in clock cycles. The block handles the period counter, the segment schedule, the level decode and the gate decode for a T-type leg with dead time.

Inputs are taken only when the period counter wraps, so every period runs one consistent vector set. A dwell pair that does not fit in the period is saturated, and a flag reports this for the whole period.

Top module: `tl_svm_seq`

## Requirements
- R1: While reset is held, and after reset until the first period wrap, the phases are at the centre state of hexagon 0: phase A = O, phases B and C = N. The gates match that state and the overmodulation flag is 0.
- R2: A period lasts PERIOD_CYC clock cycles. The hexagon, triangle and dwell inputs are sampled only on the last cycle of a period and take effect for the whole next period. Changes at any other time have no effect on the outputs.
- R3: Hexagon h (0..5) has lower centre state ring(h) and upper centre state ring(h)+1 per phase. The ring in phase order A,B,C is 100,110,010,011,001,101, with 1 adding one level. Triangle k (0..5) uses the active vectors centre+ring(k) with dwell_a and centre+ring(k+1 mod 6) with dwell_b. Select values 6 and 7 act as 0 and 1.
- R4: A period runs seven segments: lower centre for t0/4, the single-bit active vector for its dwell/2, the two-bit active vector for its dwell/2, upper centre for the remainder, then the two-bit vector, the single-bit vector and the lower centre with the same lengths again. Here t0 = PERIOD_CYC - ta - tb, and all divisions are floor.
- R5: If dwell_a + dwell_b > PERIOD_CYC-4, then ta = min(dwell_a, PERIOD_CYC-4) and tb = PERIOD_CYC-4-ta. The overmodulation flag is then 1 for that whole period, and it is 0 otherwise.
- R6: No phase ever steps directly between P and N on consecutive cycles, including across period boundaries.
- R7: The phase state encoding is N = 00, O = 01, P = 10. The code 11 never appears. Phase A is at bits [1:0], B at [3:2] and C at [5:4].
- R8: Each leg has 4 gate bits: bit0 upper switch, bit1 and bit2 midpoint switches, bit3 lower switch. P drives 0001, O drives 0110 and N drives 1000. Leg A is at [3:0], B at [7:4] and C at [11:8].
- R9: When a leg's state changes, all four of its gates are 0 for DEAD_CYC cycles, and then the new state's gates apply. The phase state output changes one cycle after the counter enters the new segment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hex_sel | input | 3 | Small hexagon index |
| tri_sel | input | 3 | Triangle index inside the hexagon |
| dwell_a | input | DW | Dwell cycles of the first active vector |
| dwell_b | input | DW | Dwell cycles of the second active vector |
| phase_st | output | 6 | Per-phase level code |
| gate_o | output | 12 | Per-leg switch gates |
| ovm_o | output | 1 | Overmodulation flag for the current period |

## Verification
The bench builds the block with a 64-cycle period, 8-bit dwell inputs and a 3-cycle dead time. The short period lets a dozen full periods run, and each one switches hexagon, triangle and dwell pair mid-period, so the sampling point of the inputs is exercised every time. The 8-bit dwell width allows values far above the 60-cycle budget, which drives both saturation branches: one dwell alone over the limit, and only the sum over it. A 3-cycle dead time is longer than some of the odd-dwell segments it meets, so a dead-time count is restarted while it is still running.

// File: rtl/tl_svm_pkg.sv
package tl_svm_pkg;

   typedef enum logic [1:0] {
      LV_N = 2'b00,
      LV_O = 2'b01,
      LV_P = 2'b10
   } lvl_t;

   localparam int NUM_PH  = 3;
   localparam int NUM_SEG = 7;

   // gate order per leg: bit0 upper, bit1/bit2 midpoint pair, bit3 lower
   function automatic logic [3:0] leg_gates(input logic [1:0] lv);
      case (lv)
         LV_P:    leg_gates = 4'b0001;
         LV_O:    leg_gates = 4'b0110;
         LV_N:    leg_gates = 4'b1000;
         default: leg_gates = 4'b0000;
      endcase
   endfunction

   // two-level ring of active states, phase A in bit 2
   function automatic logic [2:0] ring_state(input logic [2:0] idx);
      case (idx)
         3'd0:    ring_state = 3'b100;
         3'd1:    ring_state = 3'b110;
         3'd2:    ring_state = 3'b010;
         3'd3:    ring_state = 3'b011;
         3'd4:    ring_state = 3'b001;
         default: ring_state = 3'b101;
      endcase
   endfunction

endpackage

// File: rtl/svm_timing_plan.sv
module svm_timing_plan #(
   parameter int PERIOD_CYC = 64,
   parameter int DW         = 8,
   parameter int CW         = 7
) (
   input  logic [DW-1:0]        dwell_a,
   input  logic [DW-1:0]        dwell_b,
   input  logic                 tri_odd,
   output logic [5:0][CW-1:0]   edges_o,
   output logic                 ovm_o
);
   localparam int LIM = PERIOD_CYC - 4;

   int ta, tb, t0, q0, hx, hy;

   always_comb begin
      ta    = int'(dwell_a);
      tb    = int'(dwell_b);
      ovm_o = 1'b0;
      if (ta + tb > LIM) begin
         ovm_o = 1'b1;
         if (ta > LIM) ta = LIM;
         tb = LIM - ta;
      end
      t0 = PERIOD_CYC - ta - tb;
      q0 = t0 / 4;
      // the single-bit vector always leads so each step moves one level
      hx = (tri_odd ? tb : ta) / 2;
      hy = (tri_odd ? ta : tb) / 2;
      edges_o[0] = CW'(q0);
      edges_o[1] = CW'(q0 + hx);
      edges_o[2] = CW'(q0 + hx + hy);
      edges_o[3] = CW'(PERIOD_CYC - q0 - hx - hy);
      edges_o[4] = CW'(PERIOD_CYC - q0 - hx);
      edges_o[5] = CW'(PERIOD_CYC - q0);
   end

endmodule

// File: rtl/svm_vector_lut.sv
module svm_vector_lut
   import tl_svm_pkg::*;
(
   input  logic [2:0] hex_i,
   input  logic [2:0] tri_i,
   input  logic [2:0] seg_i,
   output logic [5:0] lv_o
);
   logic [2:0] h, k, kn, base, sv, dv, add;

   always_comb begin
      h  = (hex_i >= 3'd6) ? hex_i - 3'd6 : hex_i;
      k  = (tri_i >= 3'd6) ? tri_i - 3'd6 : tri_i;
      kn = (k == 3'd5) ? 3'd0 : k + 3'd1;
      base = ring_state(h);
      if (k[0]) begin
         sv = ring_state(kn);
         dv = ring_state(k);
      end else begin
         sv = ring_state(k);
         dv = ring_state(kn);
      end
      case (seg_i)
         3'd1, 3'd5: add = sv;
         3'd2, 3'd4: add = dv;
         3'd3:       add = 3'b111;
         default:    add = 3'b000;
      endcase
   end

   for (genvar p = 0; p < NUM_PH; p++) begin : g_ph
      assign lv_o[2*p +: 2] = {1'b0, base[2-p]} + {1'b0, add[2-p]};
   end

endmodule

// File: rtl/svm_leg_gate.sv
module svm_leg_gate
   import tl_svm_pkg::*;
#(
   parameter int         DEAD_CYC = 3,
   parameter logic [1:0] RST_LV   = 2'b00
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] lv_i,
   output logic [1:0] lv_o,
   output logic [3:0] gate_o
);
   logic [1:0] lv_q;

   always_ff @(posedge clk) begin
      if (!rst_n) lv_q <= RST_LV;
      else        lv_q <= lv_i;
   end
   assign lv_o = lv_q;

   if (DEAD_CYC == 0) begin : g_nodead
      assign gate_o = leg_gates(lv_q);
   end else begin : g_dead
      localparam int DCW = $clog2(DEAD_CYC + 1);
      logic [DCW-1:0] dcnt_q;
      always_ff @(posedge clk) begin
         if (!rst_n)                dcnt_q <= '0;
         else if (lv_i != lv_q)     dcnt_q <= DCW'(DEAD_CYC);
         else if (dcnt_q != '0)     dcnt_q <= dcnt_q - 1'b1;
      end
      assign gate_o = (dcnt_q != '0) ? 4'b0000 : leg_gates(lv_q);
   end

endmodule

// File: rtl/tl_svm_seq.sv
module tl_svm_seq
   import tl_svm_pkg::*;
#(
   parameter int PERIOD_CYC = 64,
   parameter int DW         = 8,
   parameter int DEAD_CYC   = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [2:0]    hex_sel,
   input  logic [2:0]    tri_sel,
   input  logic [DW-1:0] dwell_a,
   input  logic [DW-1:0] dwell_b,
   output logic [5:0]    phase_st,
   output logic [11:0]   gate_o,
   output logic          ovm_o
);
   localparam int CW = $clog2(PERIOD_CYC + 1);

   if (PERIOD_CYC < 8) begin : g_bad_period
      $error("PERIOD_CYC must be at least 8");
   end
   if (DW < 1 || DW > 16) begin : g_bad_dw
      $error("DW must be within 1..16");
   end
   if (DEAD_CYC < 0) begin : g_bad_dead
      $error("DEAD_CYC must not be negative");
   end

   logic [CW-1:0]      cnt_q;
   logic               wrap;
   logic [2:0]         hex_q, tri_q, seg;
   logic [5:0][CW-1:0] edge_q, edge_d;
   logic               ovm_q, ovm_d;
   logic [5:0]         lv_w;

   assign wrap = (cnt_q == CW'(PERIOD_CYC - 1));

   svm_timing_plan #(.PERIOD_CYC(PERIOD_CYC), .DW(DW), .CW(CW)) plan_i (
      .dwell_a (dwell_a),
      .dwell_b (dwell_b),
      .tri_odd (tri_sel[0]),
      .edges_o (edge_d),
      .ovm_o   (ovm_d)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)    cnt_q <= '0;
      else if (wrap) cnt_q <= '0;
      else           cnt_q <= cnt_q + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hex_q <= '0;
         tri_q <= '0;
         ovm_q <= 1'b0;
         for (int j = 0; j < 6; j++) edge_q[j] <= CW'(PERIOD_CYC);
      end else if (wrap) begin
         hex_q  <= hex_sel;
         tri_q  <= tri_sel;
         ovm_q  <= ovm_d;
         edge_q <= edge_d;
      end
   end

   always_comb begin
      seg = 3'd0;
      for (int j = 0; j < 6; j++) begin
         if (cnt_q >= edge_q[j]) seg = seg + 3'd1;
      end
   end

   svm_vector_lut lut_i (
      .hex_i (hex_q),
      .tri_i (tri_q),
      .seg_i (seg),
      .lv_o  (lv_w)
   );

   for (genvar p = 0; p < NUM_PH; p++) begin : g_leg
      svm_leg_gate #(
         .DEAD_CYC (DEAD_CYC),
         .RST_LV   ((p == 0) ? 2'b01 : 2'b00)
      ) leg_i (
         .clk    (clk),
         .rst_n  (rst_n),
         .lv_i   (lv_w[2*p +: 2]),
         .lv_o   (phase_st[2*p +: 2]),
         .gate_o (gate_o[4*p +: 4])
      );
   end

   assign ovm_o = ovm_q;

endmodule

// File: rtl/tl_svm_seq_chk.sv
module tl_svm_seq_chk #(
   parameter int PERIOD_CYC = 64,
   parameter int DEAD_CYC   = 3,
   parameter int CW         = 7
) (
   input logic          clk,
   input logic          rst_n,
   input logic [5:0]    phase_st,
   input logic [11:0]   gate_o,
   input logic          ovm_o,
   input logic [CW-1:0] cnt
);
   for (genvar p = 0; p < 3; p++) begin : g_ph
      AST_LEVEL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
         phase_st[2*p +: 2] != 2'b11); // R7
      AST_NO_P_TO_N: assert property (@(posedge clk) disable iff (!rst_n)
         (phase_st[2*p +: 2] == 2'b00) |-> ($past(phase_st[2*p +: 2]) != 2'b10)); // R6
      AST_NO_N_TO_P: assert property (@(posedge clk) disable iff (!rst_n)
         (phase_st[2*p +: 2] == 2'b10) |-> ($past(phase_st[2*p +: 2]) != 2'b00)); // R6
      AST_GATE_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
         (gate_o[4*p +: 4] == 4'b0000) || (gate_o[4*p +: 4] == 4'b0001) ||
         (gate_o[4*p +: 4] == 4'b0110) || (gate_o[4*p +: 4] == 4'b1000)); // R8
      if (DEAD_CYC > 0) begin : g_dead
         AST_DEAD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
            (phase_st[2*p +: 2] != $past(phase_st[2*p +: 2])) |-> (gate_o[4*p +: 4] == 4'b0000)); // R9
      end
   end

   AST_OVM_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (ovm_o != $past(ovm_o)) |-> (cnt == '0)); // R5
   AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cnt < CW'(PERIOD_CYC)); // R2

endmodule

bind tl_svm_seq tl_svm_seq_chk #(
   .PERIOD_CYC (PERIOD_CYC),
   .DEAD_CYC   (DEAD_CYC),
   .CW         (CW)
) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .phase_st (phase_st),
   .gate_o   (gate_o),
   .ovm_o    (ovm_o),
   .cnt      (cnt_q)
);

// File: tb/tl_svm_seq_tb_top.sv
module tl_svm_seq_tb_top;
   localparam int P    = 64;
   localparam int DW   = 8;
   localparam int DEAD = 3;
   localparam int LIM  = P - 4;
   localparam int NCFG = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [2:0]    hex_sel = '0;
   logic [2:0]    tri_sel = '0;
   logic [DW-1:0] dwell_a = '0;
   logic [DW-1:0] dwell_b = '0;
   logic [5:0]    phase_st;
   logic [11:0]   gate_o;
   logic          ovm_o;

   always #5 clk = ~clk;

   tl_svm_seq #(.PERIOD_CYC(P), .DW(DW), .DEAD_CYC(DEAD)) dut_i (
      .clk(clk), .rst_n(rst_n), .hex_sel(hex_sel), .tri_sel(tri_sel),
      .dwell_a(dwell_a), .dwell_b(dwell_b),
      .phase_st(phase_st), .gate_o(gate_o), .ovm_o(ovm_o)
   );

   typedef struct packed {
      logic [5:0]  ph;
      logic [11:0] g;
      logic        ov;
   } exp_t;

   exp_t q[$];
   int   checks = 0;
   int   fails  = 0;
   bit   done   = 0;
   logic [5:0] prev_ph;

   // reference model state
   int mcnt = 0, mh = 0, mk = 0, ma = 0, mb = 0;
   bit movm = 0, minit = 1;
   int mleg[3] = '{1, 0, 0};
   int mdc[3]  = '{0, 0, 0};

   function automatic int ring_bit(int idx, int p);
      logic [2:0] r;
      case (idx % 6)
         0: r = 3'b100; 1: r = 3'b110; 2: r = 3'b010;
         3: r = 3'b011; 4: r = 3'b001; default: r = 3'b101;
      endcase
      return int'(r[2-p]);
   endfunction

   function automatic logic [3:0] exp_gate(int lv);
      if (lv == 2) return 4'b0001;
      if (lv == 1) return 4'b0110;
      return 4'b1000;
   endfunction

   function automatic int model_level(int p);
      int l[7];
      int t0, f, s, acc, seg, sidx, didx, addb;
      bit found;
      if (minit) return ring_bit(0, p);
      t0 = P - ma - mb;
      f  = (mk % 2 == 0) ? ma : mb;
      s  = (mk % 2 == 0) ? mb : ma;
      l[0] = t0 / 4; l[1] = f / 2; l[2] = s / 2;
      l[4] = l[2]; l[5] = l[1]; l[6] = l[0];
      l[3] = P - 2 * (l[0] + l[1] + l[2]);
      acc = 0; seg = 6; found = 0;
      for (int j = 0; j < 7; j++) begin
         acc += l[j];
         if (!found && mcnt < acc) begin seg = j; found = 1; end
      end
      sidx = (mk % 2 == 0) ? mk : (mk + 1) % 6;
      didx = (mk % 2 == 0) ? (mk + 1) % 6 : mk;
      case (seg)
         1, 5:    addb = ring_bit(sidx, p);
         2, 4:    addb = ring_bit(didx, p);
         3:       addb = 1;
         default: addb = 0;
      endcase
      return ring_bit(mh, p) + addb;
   endfunction

   // driver side: model advances with the clock and queues the expected outputs
   always @(posedge clk) begin
      if (rst_n) begin
         exp_t e;
         int lv[3];
         int a, b;
         for (int p = 0; p < 3; p++) lv[p] = model_level(p);
         for (int p = 0; p < 3; p++) begin
            if (lv[p] != mleg[p]) begin mleg[p] = lv[p]; mdc[p] = DEAD; end
            else if (mdc[p] > 0) mdc[p] = mdc[p] - 1;
         end
         if (mcnt == P - 1) begin
            mcnt  = 0;
            minit = 0;
            mh = (int'(hex_sel) >= 6) ? int'(hex_sel) - 6 : int'(hex_sel);
            mk = (int'(tri_sel) >= 6) ? int'(tri_sel) - 6 : int'(tri_sel);
            a = int'(dwell_a); b = int'(dwell_b);
            movm = (a + b > LIM);
            if (movm) begin
               if (a > LIM) a = LIM;
               b = LIM - a;
            end
            ma = a; mb = b;
         end else begin
            mcnt++;
         end
         for (int p = 0; p < 3; p++) begin
            e.ph[2*p +: 2] = 2'(mleg[p]);
            e.g[4*p +: 4]  = (mdc[p] != 0) ? 4'b0000 : exp_gate(mleg[p]);
         end
         e.ov = movm;
         q.push_back(e);
      end
   end

   // monitor: pops and compares away from the active edge
   always @(negedge clk) begin
      if (q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         checks++;
         if (phase_st !== e.ph) begin
            fails++;
            $display("FAIL R2/R3/R4 phase_st actual=%b expected=%b", phase_st, e.ph);
         end
         checks++;
         if (gate_o !== e.g) begin
            fails++;
            $display("FAIL R8/R9 gate_o actual=%b expected=%b", gate_o, e.g);
         end
         checks++;
         if (ovm_o !== e.ov) begin
            fails++;
            $display("FAIL R5 ovm_o actual=%b expected=%b", ovm_o, e.ov);
         end
         for (int p = 0; p < 3; p++) begin
            checks++;
            if ((phase_st[2*p +: 2] == 2'b10 && prev_ph[2*p +: 2] == 2'b00) ||
                (phase_st[2*p +: 2] == 2'b00 && prev_ph[2*p +: 2] == 2'b10)) begin
               fails++;
               $display("FAIL R6 phase %0d step actual=%b expected adjacent to %b",
                        p, phase_st[2*p +: 2], prev_ph[2*p +: 2]);
            end
            checks++;
            if (phase_st[2*p +: 2] == 2'b11) begin
               fails++;
               $display("FAIL R7 phase %0d code actual=11 expected 00/01/10", p);
            end
         end
         prev_ph = phase_st;
      end
   end

   int cfg_h[NCFG] = '{0, 0, 1, 2, 3, 4, 5, 6, 2, 1, 7, 3};
   int cfg_k[NCFG] = '{0, 1, 2, 3, 4, 5, 0, 7, 5, 3, 6, 2};
   int cfg_a[NCFG] = '{20, 10, 7, 0, 40, 200, 1, 16, 60, 30, 5, 255};
   int cfg_b[NCFG] = '{12, 30, 9, 0, 40, 10, 1, 16, 0, 31, 50, 255};

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1 reset state
      checks++;
      if (phase_st !== 6'b000001) begin
         fails++;
         $display("FAIL R1 phase_st actual=%b expected=%b", phase_st, 6'b000001);
      end
      checks++;
      if (gate_o !== 12'b1000_1000_0110) begin
         fails++;
         $display("FAIL R1 gate_o actual=%b expected=%b", gate_o, 12'b1000_1000_0110);
      end
      checks++;
      if (ovm_o !== 1'b0) begin
         fails++;
         $display("FAIL R1 ovm_o actual=%b expected=0", ovm_o);
      end
      prev_ph = phase_st;
      // inputs change mid-period so the wrap sampling of R2 is exercised
      repeat (P / 2) @(negedge clk);
      for (int i = 0; i < NCFG; i++) begin
         hex_sel = 3'(cfg_h[i]);
         tri_sel = 3'(cfg_k[i]);
         dwell_a = DW'(cfg_a[i]);
         dwell_b = DW'(cfg_b[i]);
         repeat (P) @(negedge clk);
      end
      repeat (P + 4) @(negedge clk);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #(200000 * 10);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule